// File: doc/BRIEF.md
# Periodic Interrupt Generator with Jumper-Selected Interval

This block makes the periodic interrupt for the main processor of an 8-bit pinball controller. It runs on the 1 MHz E clock, which is the 4 MHz crystal divided by four, so one `clk` cycle is one E-clock tick. The output alternates between two phases. In the idle gap phase the interrupt line is low. The gap is followed by a pulse of fixed length during which the line is high. Two jumper inputs choose the gap length from four values.

The pulse also drives three peripheral control pins. A strobe to the sound-side adapter is low during the pulse. Two display-side inputs carry the diagnostic push-button levels, which are captured when the pulse begins. The diagnostic levels are only seen by the display adapter while the pulse is running.

When any other peripheral raises an interrupt request, the generator stops and reports itself busy. When that request clears, the generator starts a complete fresh gap.

Top module: `irq_tick_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `irq_o` and `irq_active_o` are 0, and `snd_cb1_o`, `disp_ca1_o` and `disp_cb1_o` are 1.
- R2: In steady running, `irq_o` stays low for exactly G cycles between pulses. G is 0x300 for `gap_sel`=00, 0x380 for 01 (the default fitting), 0x700 for 10 and 0x780 for 11. Bit 0 adds 0x80 and bit 1 adds 0x400.
- R3: Each pulse that is not cut short by a peripheral request keeps `irq_o` high for exactly 32 cycles.
- R4: `snd_cb1_o` is 0 in every cycle that `irq_o` is 1, and 1 in every cycle that it is 0.
- R5: During a pulse, `disp_ca1_o` shows `diag_btn[0]` (Advance) and `disp_cb1_o` shows `diag_btn[1]` (Up/Down). Both are sampled on the edge that starts the pulse and held for the whole pulse, even if the buttons change.
- R6: Outside a pulse, `disp_ca1_o` and `disp_cb1_o` are both 1, whatever the buttons do.
- R7: While `periph_irq` is 1, the generator is held. From the next cycle on, `irq_active_o` is 1, `irq_o` is 0 and every strobe output is at its idle level. This applies even if the request arrives in the middle of a pulse, and no pulse starts however long the hold lasts.
- R8: On the first edge at which `periph_irq` is 0 after a hold, `irq_active_o` clears. A full gap of G cycles then follows before the next pulse.
- R9: `gap_sel` is sampled only when a gap count is loaded: at reset, at the end of a pulse, or at hold release. A change made in the middle of a gap leaves that gap's length unchanged and applies to the next gap.
- R10: If `periph_irq` rises on the same edge at which the gap would expire, the hold wins: no pulse is issued, and `irq_active_o` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | E clock (one tick per cycle) |
| rst_n | input | 1 | Synchronous reset, active low |
| gap_sel | input | 2 | Jumper setting that selects the gap length |
| periph_irq | input | 1 | Pending interrupt from other peripherals, active high |
| diag_btn | input | 2 | Diagnostic buttons: [0] Advance, [1] Up/Down |
| irq_o | output | 1 | Periodic interrupt to the main CPU, active high |
| snd_cb1_o | output | 1 | Strobe to the sound adapter; 0 during a pulse |
| disp_ca1_o | output | 1 | Advance level to the display adapter; 1 outside a pulse |
| disp_cb1_o | output | 1 | Up/Down level to the display adapter; 1 outside a pulse |
| irq_active_o | output | 1 | High while held by a peripheral request |

## Verification
The gap expiring and a peripheral request arriving can fall on the same edge. In that case the timer has two competing next states: starting a pulse or entering the hold. The bench counts low samples after a falling edge of `irq_o` and raises `periph_irq` on exactly the G-th sample. The test passes only if `irq_o` stays low on the following cycle, `irq_active_o` is set, and the release is followed by a full gap. A second overlap comes from a jumper change landing inside a gap. It is judged by checking that the running gap keeps its old length and the next gap takes the new one.

// File: rtl/irq_tick_gen_pkg.sv
// Shared types for the periodic interrupt generator.
// Assumes: one timer phase is active at a time; the hold phase only exists
// while a peripheral interrupt request is pending.
package irq_tick_gen_pkg;

    typedef enum logic [1:0] {
        PH_GAP   = 2'd0,
        PH_PULSE = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

endpackage

// File: rtl/irq_gap_sel.sv
// Turns the jumper setting into a gap length in E-clock cycles.
// Each jumper bit adds its own step to a base length. The sum is formed
// through a generate chain so that the number of jumper bits is a parameter.
// Assumes: the largest sum fits in CNT_W bits.
module irq_gap_sel #(
    parameter int GAP_BASE    = 'h300,
    parameter int GAP_STEP_LO = 'h80,
    parameter int GAP_STEP_HI = 'h400,
    parameter int SEL_W       = 2,
    parameter int CNT_W       = 11
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] gap_len
);

    // running partial sums, one stage per jumper bit
    logic [CNT_W-1:0] part [SEL_W+1];

    assign part[0] = CNT_W'(GAP_BASE);

    for (genvar i = 0; i < SEL_W; i++) begin : g_step
        localparam int STEP = (i == 0) ? GAP_STEP_LO : (GAP_STEP_HI << (i - 1));
        assign part[i+1] = part[i] + (sel[i] ? CNT_W'(STEP) : '0);
    end

    assign gap_len = part[SEL_W];

endmodule

// File: rtl/irq_phase_timer.sv
// Phase sequencer and down-counter for the interrupt generator.
// Gap phase: counts gap_len cycles and then enters the pulse phase.
// Pulse phase: counts PULSE_LEN cycles and then reloads the gap.
// A hold request overrides both and parks the timer. Releasing the
// request reloads a full gap.
// Assumes: gap_len >= 1 and PULSE_LEN >= 1.
module irq_phase_timer
    import irq_tick_gen_pkg::*;
#(
    parameter int PULSE_LEN = 32,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gap_len,
    input  logic             hold_req,
    output phase_e           phase,
    output logic             pulse_start
);

    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] gap_load;

    // value loaded whenever a gap begins; this is the only use of gap_sel
    assign gap_load = gap_len - 1'b1;

    // gap expires on this edge and no hold wins over it
    assign pulse_start = (phase == PH_GAP) && (cnt == '0) && !hold_req;

    // advance the phase and counter by one E-clock tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_GAP;
            cnt   <= gap_load;
        end else if (hold_req) begin
            phase <= PH_HOLD;
        end else begin
            unique case (phase)
                PH_HOLD: begin
                    phase <= PH_GAP;
                    cnt   <= gap_load;
                end
                PH_GAP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= PULSE_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        phase <= PH_GAP;
                        cnt   <= gap_load;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_GAP;
                    cnt   <= gap_load;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_diag_gate.sv
// Captures the diagnostic buttons at pulse start and drives them onto the
// display adapter inputs while the pulse lasts. Both pins idle at 1.
// Assumes: capture is a single-cycle strobe on the edge that starts a pulse.
module irq_diag_gate #(
    parameter int DIAG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              in_pulse,
    input  logic [DIAG_W-1:0] diag_btn,
    output logic [DIAG_W-1:0] diag_pins
);

    logic [DIAG_W-1:0] diag_q;

    // hold the button levels that were present when the pulse began
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diag_q <= '1;
        end else if (capture) begin
            diag_q <= diag_btn;
        end
    end

    // drive the captured levels only while the pulse runs
    for (genvar i = 0; i < DIAG_W; i++) begin : g_pin
        assign diag_pins[i] = in_pulse ? diag_q[i] : 1'b1;
    end

endmodule

// File: rtl/irq_tick_gen.sv
// Periodic interrupt generator for a pinball main processor.
// Counts E-clock ticks: the gap length is chosen by jumpers, then a
// fixed-length high pulse on irq_o follows. The pulse also gives the sound
// strobe and the diagnostic levels to the display adapter. A pending
// peripheral interrupt parks the timer; its release restarts a full gap.
// Assumes: clk is the E clock; all inputs are synchronous to it.
module irq_tick_gen
    import irq_tick_gen_pkg::*;
#(
    parameter int GAP_BASE    = 'h300,
    parameter int GAP_STEP_LO = 'h80,
    parameter int GAP_STEP_HI = 'h400,
    parameter int PULSE_LEN   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gap_sel,
    input  logic       periph_irq,
    input  logic [1:0] diag_btn,
    output logic       irq_o,
    output logic       snd_cb1_o,
    output logic       disp_ca1_o,
    output logic       disp_cb1_o,
    output logic       irq_active_o
);

    localparam int SEL_W   = 2;
    localparam int DIAG_W  = 2;
    localparam int GAP_MAX = GAP_BASE + GAP_STEP_LO + GAP_STEP_HI;
    localparam int CNT_MAX = (GAP_MAX > PULSE_LEN) ? GAP_MAX : PULSE_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]  gap_len;
    phase_e            phase;
    logic              pulse_start;
    logic              in_pulse;
    logic [DIAG_W-1:0] diag_pins;

    irq_gap_sel #(
        .GAP_BASE   (GAP_BASE),
        .GAP_STEP_LO(GAP_STEP_LO),
        .GAP_STEP_HI(GAP_STEP_HI),
        .SEL_W      (SEL_W),
        .CNT_W      (CNT_W)
    ) u_gap_sel (
        .sel    (gap_sel),
        .gap_len(gap_len)
    );

    irq_phase_timer #(
        .PULSE_LEN(PULSE_LEN),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gap_len    (gap_len),
        .hold_req   (periph_irq),
        .phase      (phase),
        .pulse_start(pulse_start)
    );

    assign in_pulse = (phase == PH_PULSE);

    irq_diag_gate #(
        .DIAG_W(DIAG_W)
    ) u_diag (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (pulse_start),
        .in_pulse (in_pulse),
        .diag_btn (diag_btn),
        .diag_pins(diag_pins)
    );

    // output pins taken from the registered phase
    assign irq_o        = in_pulse;
    assign snd_cb1_o    = !in_pulse;
    assign disp_ca1_o   = diag_pins[0];
    assign disp_cb1_o   = diag_pins[1];
    assign irq_active_o = (phase == PH_HOLD);

endmodule

// File: rtl/irq_tick_gen_chk.sv
// Protocol checker for irq_tick_gen, attached through bind.
// It measures high and low run lengths with its own counters.
module irq_tick_gen_chk #(
    parameter int GAP_BASE    = 'h300,
    parameter int GAP_STEP_LO = 'h80,
    parameter int GAP_STEP_HI = 'h400,
    parameter int PULSE_LEN   = 32
) (
    input logic clk,
    input logic rst_n,
    input logic periph_irq,
    input logic irq_o,
    input logic snd_cb1_o,
    input logic disp_ca1_o,
    input logic disp_cb1_o,
    input logic irq_active_o
);

    localparam int G0 = GAP_BASE;
    localparam int G1 = GAP_BASE + GAP_STEP_LO;
    localparam int G2 = GAP_BASE + GAP_STEP_HI;
    localparam int G3 = GAP_BASE + GAP_STEP_LO + GAP_STEP_HI;

    int hi_run;
    int lo_run;

    // run-length counters for the high pulse and the unheld low gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= irq_o ? hi_run + 1 : 0;
            lo_run <= (!irq_o && !irq_active_o) ? lo_run + 1 : 0;
        end
    end

    assert_gap_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (lo_run == G0 || lo_run == G1 || lo_run == G2 || lo_run == G3));

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_o) && !irq_active_o) |-> (hi_run == PULSE_LEN));

    assert_snd_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !snd_cb1_o);

    assert_diag_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> ($stable(disp_ca1_o) && $stable(disp_cb1_o)));

    assert_diag_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (disp_ca1_o && disp_cb1_o));

    assert_hold_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_irq |=> (irq_active_o && !irq_o && snd_cb1_o));

    assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active_o && !periph_irq) |=> (!irq_active_o && !irq_o));

endmodule

bind irq_tick_gen irq_tick_gen_chk #(
    .GAP_BASE   (GAP_BASE),
    .GAP_STEP_LO(GAP_STEP_LO),
    .GAP_STEP_HI(GAP_STEP_HI),
    .PULSE_LEN  (PULSE_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_irq  (periph_irq),
    .irq_o       (irq_o),
    .snd_cb1_o   (snd_cb1_o),
    .disp_ca1_o  (disp_ca1_o),
    .disp_cb1_o  (disp_cb1_o),
    .irq_active_o(irq_active_o)
);

// File: tb/irq_tick_gen_bench.sv
`timescale 1ns/1ps
module irq_tick_gen_bench;

    localparam int PULSE = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] gap_sel = 2'b01;
    logic       periph_irq = 1'b0;
    logic [1:0] diag_btn = 2'b11;
    logic       irq_o, snd_cb1_o, disp_ca1_o, disp_cb1_o, irq_active_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    irq_tick_gen u_irq_tick_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .gap_sel     (gap_sel),
        .periph_irq  (periph_irq),
        .diag_btn    (diag_btn),
        .irq_o       (irq_o),
        .snd_cb1_o   (snd_cb1_o),
        .disp_ca1_o  (disp_ca1_o),
        .disp_cb1_o  (disp_cb1_o),
        .irq_active_o(irq_active_o)
    );

    function automatic int gap_of(input logic [1:0] s);
        return 'h300 + (s[0] ? 'h80 : 0) + (s[1] ? 'h400 : 0);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl);
        int guard = 0;
        while (irq_o !== lvl && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // counts one full high run then one full low run, watching the strobe
    task automatic measure(output int hi, output int lo, output int serr);
        hi = 0; lo = 0; serr = 0;
        wait_level(1'b1);
        do begin
            hi++;
            if (snd_cb1_o !== 1'b0) serr++;
            @(negedge clk);
        end while (irq_o === 1'b1 && hi < 5000);
        do begin
            lo++;
            if (snd_cb1_o !== 1'b1) serr++;
            @(negedge clk);
        end while (irq_o === 1'b0 && lo < 5000);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 irq in reset", irq_o, 0);
        check("R1 active in reset", irq_active_o, 0);
        check("R1 strobes in reset", {snd_cb1_o, disp_ca1_o, disp_cb1_o}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", irq_o, 0);
        check("R1 strobes after reset", {irq_active_o, snd_cb1_o, disp_ca1_o, disp_cb1_o}, 4'b0111);
    endtask

    task automatic t_periods();
        int hi, lo, serr;
        for (int s = 0; s < 4; s++) begin
            gap_sel = 2'(s);
            measure(hi, lo, serr);   // first run may straddle the change
            measure(hi, lo, serr);
            check($sformatf("R2 gap sel=%0d", s), lo, gap_of(2'(s)));
            check($sformatf("R3 pulse sel=%0d", s), hi, PULSE);
            check($sformatf("R4 strobe sel=%0d", s), serr, 0);
        end
    endtask

    task automatic t_diag();
        gap_sel = 2'b00;
        wait_level(1'b0);
        diag_btn = 2'b01;
        @(negedge clk);
        check("R6 idle ca1/cb1 with buttons", {disp_ca1_o, disp_cb1_o}, 2'b11);
        wait_level(1'b1);
        check("R5 ca1 = advance", disp_ca1_o, 1);
        check("R5 cb1 = up/down", disp_cb1_o, 0);
        diag_btn = 2'b10;
        repeat (3) @(negedge clk);
        check("R5 held during pulse", {disp_ca1_o, disp_cb1_o}, 2'b10);
        wait_level(1'b0);
        check("R6 idle after pulse", {disp_ca1_o, disp_cb1_o}, 2'b11);
        diag_btn = 2'b11;
    endtask

    task automatic release_and_count(input string req, input int exp);
        int lo = 0;
        periph_irq = 1'b0;
        @(negedge clk);
        check({req, " active cleared"}, irq_active_o, 0);
        while (irq_o === 1'b0 && lo < 5000) begin
            lo++;
            @(negedge clk);
        end
        check({req, " full gap after release"}, lo, exp);
    endtask

    task automatic t_hold_gap();
        int seen = 0;
        gap_sel = 2'b00;
        wait_level(1'b0);
        repeat (100) @(negedge clk);
        periph_irq = 1'b1;
        @(negedge clk);
        check("R7 active set", irq_active_o, 1);
        repeat (2500) begin
            if (irq_o !== 1'b0) seen++;
            @(negedge clk);
        end
        check("R7 no pulse while held", seen, 0);
        release_and_count("R8", gap_of(2'b00));
    endtask

    task automatic t_hold_pulse();
        wait_level(1'b1);
        repeat (5) @(negedge clk);
        periph_irq = 1'b1;
        @(negedge clk);
        check("R7 pulse cut", irq_o, 0);
        check("R7 idle strobes in hold",
              {irq_active_o, snd_cb1_o, disp_ca1_o, disp_cb1_o}, 4'b1111);
        repeat (20) @(negedge clk);
        release_and_count("R8 after cut", gap_of(2'b00));
    endtask

    task automatic t_jumper_change();
        int lo = 0, hi, serr;
        gap_sel = 2'b00;
        measure(hi, lo, serr);
        wait_level(1'b0);
        lo = 0;
        while (irq_o === 1'b0 && lo < 5000) begin
            lo++;
            if (lo == 10) gap_sel = 2'b11;
            @(negedge clk);
        end
        check("R9 running gap unchanged", lo, gap_of(2'b00));
        measure(hi, lo, serr);
        check("R9 next gap uses new jumper", lo, gap_of(2'b11));
    endtask

    task automatic t_collision();
        int g = gap_of(2'b00);
        gap_sel = 2'b00;
        wait_level(1'b1);
        wait_level(1'b0);             // first low sample
        repeat (g - 1) @(negedge clk); // now at last low sample of the gap
        periph_irq = 1'b1;
        @(negedge clk);
        check("R10 hold wins, no pulse", irq_o, 0);
        check("R10 active set", irq_active_o, 1);
        repeat (3) @(negedge clk);
        release_and_count("R10", g);
    endtask

    initial begin
        #(20ns * 190000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_periods();
        t_diag();
        t_hold_gap();
        t_hold_pulse();
        t_jumper_change();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule